// File: doc/BRIEF.md
# Register Bank with Per-Bit Write Modifiers

This block is a small bank of software-visible registers. Each register holds one field, and each field picks its write behaviour at elaboration time. A field can take plain writes, where the written bytes replace its contents. It can also take one of six bitwise modes, where a chosen written bit value (one or zero) sets, clears or inverts the matching bit and the other value leaves the bit alone. Software can therefore change one bit in a single bus write, with no read-modify-write sequence and no risk of disturbing the neighbouring bits.

The bus side is a plain synchronous port with a word address, write enable, write data, byte strobes, read enable and registered read data. The hardware side has a set vector and a clear vector per field, plus the current value of every field as an output. A hardware event that lands in the same cycle as a software write to the same bit takes priority over the write.

Top module: `regbank_bitmod`

## Requirements
- R1: While reset is held, and after it is released, every field holds its parameterised reset value and `bus_rdata` is zero until the first read.
- R2: A field with mode code 0 (plain) takes the written data in every byte whose strobe is set.
- R3: A field with mode code 1 sets each bit written as 1. A field with mode code 4 sets each bit written as 0. The opposite written value leaves the bit unchanged.
- R4: A field with mode code 2 clears each bit written as 1. A field with mode code 5 clears each bit written as 0. The opposite written value leaves the bit unchanged.
- R5: A field with mode code 3 inverts each bit written as 1. A field with mode code 6 inverts each bit written as 0. The opposite written value leaves the bit unchanged.
- R6: The spare mode code 7 behaves exactly like plain mode.
- R7: Strobe bit k covers data bits 8k to 8k+7. A byte whose strobe is low keeps its value in every mode.
- R8: In the same cycle, an asserted `hw_set` bit forces that field bit to 1 and an asserted `hw_clr` bit forces it to 0. Both override any software write to that bit, and set wins over clear.
- R9: A read with `bus_ren` high returns, on the next cycle, the value the addressed field held at the read edge. The read has no side effect on any field. Between reads, `bus_rdata` holds its value.
- R10: Addresses at or above the number of registers read as zero, and writes to them change no field.
- R11: Field i sits at word address i, and a write changes only the addressed field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word address |
| bus_wen | input | 1 | Write enable |
| bus_wdata | input | DW | Write data |
| bus_wstrb | input | DW/8 | Byte strobes |
| bus_ren | input | 1 | Read enable |
| bus_rdata | output | DW | Registered read data |
| hw_set | input | NUM_REGS*DW | Hardware set vector, field i at bits i*DW upward |
| hw_clr | input | NUM_REGS*DW | Hardware clear vector, same layout |
| field_q | output | NUM_REGS*DW | Current field values, same layout |

## Verification
The assertions check on every cycle that:
- a field in a set mode never loses a bit unless a hardware clear is present;
- a field in a clear mode never gains one unless a hardware set is present;
- unstrobed bytes stay put;
- hardware set and clear bits always land;
- unmapped writes leave all fields stable and unmapped reads return zero;
- read data holds between reads.

Only the bench scenarios can show the exact result of each mode on each mix of start value, data and strobe. The same holds for the collision ordering against a software write, and for whether a neighbouring field stays undisturbed by a write elsewhere.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [2:0] {
    WM_PLAIN = 3'd0,
    WM_SET1  = 3'd1,
    WM_CLR1  = 3'd2,
    WM_TGL1  = 3'd3,
    WM_SET0  = 3'd4,
    WM_CLR0  = 3'd5,
    WM_TGL0  = 3'd6,
    WM_SPARE = 3'd7
  } wmode_e;
endpackage

// File: rtl/regbank_rst_sync.sv
module regbank_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/regbank_addr_dec.sv
module regbank_addr_dec #(
  parameter int NUM_REGS = 4,
  parameter int ADDR_W   = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wen,
  output logic [NUM_REGS-1:0] wsel,
  output logic                hit,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    hit = (int'(addr) < NUM_REGS);
    idx = IDX_W'(addr);
    for (int i = 0; i < NUM_REGS; i++) begin
      wsel[i] = wen && (int'(addr) == i);
    end
  end

  // R11: at most one field is selected by a write
  always_comb begin
    a_r11_onehot_sel: assert ($onehot0(wsel));
  end
endmodule

// File: rtl/regbank_field.sv
module regbank_field
  import regbank_pkg::*;
#(
  parameter int          DW    = 32,
  parameter logic [2:0]  MODE  = 3'd0,
  parameter logic [DW-1:0] RESET = '0,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wsel,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wstrb,
  input  logic [DW-1:0] hw_set,
  input  logic [DW-1:0] hw_clr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_r;
  logic [DW-1:0] wmask;
  logic [DW-1:0] sw_hit;
  logic [DW-1:0] sw_miss;
  logic [DW-1:0] sw_next;
  logic [DW-1:0] d_next;
  logic          upd_en;

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wmask[8*b +: 8] = {8{wsel & wstrb[b]}};
  end

  assign sw_hit  = wmask & wdata;
  assign sw_miss = wmask & ~wdata;

  case (MODE)
    WM_SET1: begin : g_set1 assign sw_next = q_r | sw_hit;   end
    WM_CLR1: begin : g_clr1 assign sw_next = q_r & ~sw_hit;  end
    WM_TGL1: begin : g_tgl1 assign sw_next = q_r ^ sw_hit;   end
    WM_SET0: begin : g_set0 assign sw_next = q_r | sw_miss;  end
    WM_CLR0: begin : g_clr0 assign sw_next = q_r & ~sw_miss; end
    WM_TGL0: begin : g_tgl0 assign sw_next = q_r ^ sw_miss;  end
    default: begin : g_plain assign sw_next = (q_r & ~wmask) | sw_hit; end
  endcase

  always_comb begin
    d_next = (sw_next & ~hw_clr) | hw_set;
    upd_en = (|wmask) | (|hw_set) | (|hw_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_r <= RESET;
    else if (upd_en) q_r <= d_next;
  end

  assign q = q_r;

  // R8: hardware set bits always land, hardware clear bits land unless set
  a_r8_hw_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((q_r & $past(hw_set)) == $past(hw_set)));
  a_r8_hw_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_clr & ~hw_set) != '0) |=> ((q_r & $past(hw_clr & ~hw_set)) == '0));

  // R7: an unstrobed byte without hardware events keeps its value
  for (genvar b = 0; b < NB; b++) begin : g_hold
    a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wsel && wstrb[b]) && hw_set[8*b +: 8] == '0 && hw_clr[8*b +: 8] == '0)
      |=> $stable(q_r[8*b +: 8]));
  end

  if (MODE == WM_SET1 || MODE == WM_SET0) begin : g_chk_set
    // R3: a set-mode field only loses bits through hardware clear
    a_r3_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_clr == '0) |=> ((q_r & $past(q_r)) == $past(q_r)));
  end
  if (MODE == WM_CLR1 || MODE == WM_CLR0) begin : g_chk_clr
    // R4: a clear-mode field only gains bits through hardware set
    a_r4_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_set == '0) |=> ((q_r & ~$past(q_r)) == '0));
  end
endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port #(
  parameter int NUM_REGS = 4,
  parameter int DW       = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ren,
  input  logic                   hit,
  input  logic [IDX_W-1:0]       idx,
  input  logic [NUM_REGS*DW-1:0] fields,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] rd_next;
  logic [DW-1:0] rdata_r;

  always_comb begin
    rd_next = '0;
    if (hit) rd_next = fields[int'(idx)*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_r <= '0;
    else if (ren) rdata_r <= rd_next;
  end

  assign rdata = rdata_r;

  // R10: unmapped reads return zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && !hit) |=> (rdata_r == '0));
  // R9: read data holds between reads
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ren |=> $stable(rdata_r));
endmodule

// File: rtl/regbank_bitmod.sv
module regbank_bitmod
  import regbank_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int DW       = 32,
  parameter int ADDR_W   = 4,
  parameter logic [NUM_REGS*3-1:0]  FIELD_MODES = {3'd3, 3'd2, 3'd1, 3'd0},
  parameter logic [NUM_REGS*DW-1:0] FIELD_RESET = '0,
  localparam int NB    = DW / 8,
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_wen,
  input  logic [DW-1:0]          bus_wdata,
  input  logic [NB-1:0]          bus_wstrb,
  input  logic                   bus_ren,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NUM_REGS*DW-1:0] hw_set,
  input  logic [NUM_REGS*DW-1:0] hw_clr,
  output logic [NUM_REGS*DW-1:0] field_q
);
  logic                rst_sync_n;
  logic [NUM_REGS-1:0] wsel;
  logic                hit;
  logic [IDX_W-1:0]    idx;

  regbank_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  regbank_addr_dec #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .wen  (bus_wen),
    .wsel (wsel),
    .hit  (hit),
    .idx  (idx)
  );

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_field
    regbank_field #(
      .DW    (DW),
      .MODE  (FIELD_MODES[3*i +: 3]),
      .RESET (FIELD_RESET[DW*i +: DW])
    ) u_field (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .wsel   (wsel[i]),
      .wdata  (bus_wdata),
      .wstrb  (bus_wstrb),
      .hw_set (hw_set[DW*i +: DW]),
      .hw_clr (hw_clr[DW*i +: DW]),
      .q      (field_q[DW*i +: DW])
    );
  end

  regbank_rd_port #(.NUM_REGS(NUM_REGS), .DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .ren    (bus_ren),
    .hit    (hit),
    .idx    (idx),
    .fields (field_q),
    .rdata  (bus_rdata)
  );

  // R10: a write to an unmapped address leaves every field stable
  a_r10_unmapped_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wen && int'(bus_addr) >= NUM_REGS && hw_set == '0 && hw_clr == '0)
    |=> $stable(field_q));
endmodule

// File: tb/test_regbank_bitmod.sv
module test_regbank_bitmod;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam logic [NR*3-1:0] MODES =
    {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
  localparam logic [NR*DW-1:0] RSTV =
    {16'h7E81, 16'h6C39, 16'h5A5A, 16'h4BAD, 16'h3F00, 16'h2468, 16'h1357, 16'h0C0C};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_wen = 1'b0;
  logic [DW-1:0]   bus_wdata = '0;
  logic [1:0]      bus_wstrb = '0;
  logic            bus_ren = 1'b0;
  logic [DW-1:0]   bus_rdata;
  logic [NR*DW-1:0] hw_set = '0;
  logic [NR*DW-1:0] hw_clr = '0;
  logic [NR*DW-1:0] field_q;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] exp_q [NR];

  always #4 clk = ~clk;

  regbank_bitmod #(
    .NUM_REGS(NR), .DW(DW), .ADDR_W(AW),
    .FIELD_MODES(MODES), .FIELD_RESET(RSTV)
  ) i_regbank_bitmod (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_ren(bus_ren),
    .bus_rdata(bus_rdata), .hw_set(hw_set), .hw_clr(hw_clr), .field_q(field_q)
  );

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic string mode_tag(input int m);
    case (m)
      1, 4:    return "R3";
      2, 5:    return "R4";
      3, 6:    return "R5";
      7:       return "R6";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [DW-1:0] model(input int m, input logic [DW-1:0] q,
                                          input logic [DW-1:0] w, input logic [1:0] s);
    logic [DW-1:0] mk;
    mk = {{8{s[1]}}, {8{s[0]}}};
    case (m)
      1: return q | (w & mk);
      2: return q & ~(w & mk);
      3: return q ^ (w & mk);
      4: return q | (~w & mk);
      5: return q & ~(~w & mk);
      6: return q ^ (~w & mk);
      default: return (q & ~mk) | (w & mk);
    endcase
  endfunction

  task automatic check_fields(input string req);
    for (int i = 0; i < NR; i++) begin
      check(field_q[DW*i +: DW] === exp_q[i], req, field_q[DW*i +: DW], exp_q[i]);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d, input logic [1:0] s);
    @(negedge clk);
    bus_addr = AW'(a); bus_wdata = d; bus_wstrb = s; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic do_load(input int r, input logic [DW-1:0] v);
    @(negedge clk);
    hw_set[DW*r +: DW] = v; hw_clr[DW*r +: DW] = ~v;
    @(negedge clk);
    hw_set = '0; hw_clr = '0;
    exp_q[r] = v;
  endtask

  task automatic do_read(input int a, input logic [DW-1:0] expv, input string req);
    @(negedge clk);
    bus_addr = AW'(a); bus_ren = 1'b1;
    @(negedge clk);
    bus_ren = 1'b0;
    check(bus_rdata === expv, req, bus_rdata, expv);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] starts [4];
    logic [DW-1:0] datas  [4];
    logic [DW-1:0] keep;
    starts = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h0F0F};
    datas  = '{16'h0000, 16'hFFFF, 16'h5A3C, 16'h00F0};
    for (int i = 0; i < NR; i++) exp_q[i] = RSTV[DW*i +: DW];

    // R1: reset state while held and after release
    repeat (3) @(negedge clk);
    check_fields("R1");
    check(bus_rdata === '0, "R1", bus_rdata, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_fields("R1");
    check(bus_rdata === '0, "R1", bus_rdata, '0);
    do_read(3, RSTV[DW*3 +: DW], "R9");

    // R2..R7, R11: sweep of every mode, start value, data and strobe
    for (int r = 0; r < NR; r++) begin
      for (int si = 0; si < 4; si++) begin
        for (int di = 0; di < 4; di++) begin
          for (int s = 0; s < 4; s++) begin
            do_load(r, starts[si]);
            exp_q[r] = model(r, starts[si], datas[di], 2'(s));
            do_write(r, datas[di], 2'(s));
            check(field_q[DW*r +: DW] === exp_q[r],
                  (s == 0) ? "R7" : mode_tag(r), field_q[DW*r +: DW], exp_q[r]);
            check_fields("R11");
            do_read(r, exp_q[r], "R9");
          end
        end
      end
    end

    // R9: repeated reads of a toggle field cause no change
    do_load(3, 16'h1234);
    do_read(3, 16'h1234, "R9");
    do_read(3, 16'h1234, "R9");
    check_fields("R9");

    // R10: unmapped writes ignored, unmapped reads zero
    for (int a = NR; a < 16; a++) begin
      do_write(a, 16'hFFFF, 2'b11);
      check_fields("R10");
      do_read(a, '0, "R10");
    end

    // R8: hardware events beat a software write in the same cycle
    do_load(0, 16'h0000);
    @(negedge clk);
    bus_addr = 0; bus_wdata = 16'h0000; bus_wstrb = 2'b11; bus_wen = 1'b1;
    hw_set[3] = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; hw_set = '0;
    exp_q[0] = 16'h0008;
    check(field_q[15:0] === 16'h0008, "R8", field_q[15:0], 16'h0008);

    do_load(1, 16'h0000);
    @(negedge clk);
    bus_addr = 1; bus_wdata = 16'h0020; bus_wstrb = 2'b11; bus_wen = 1'b1;
    hw_clr[DW*1 + 5] = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; hw_clr = '0;
    check(field_q[DW*1 +: DW] === 16'h0000, "R8", field_q[DW*1 +: DW], 16'h0000);

    do_load(3, 16'h00FF);
    @(negedge clk);
    bus_addr = 3; bus_wdata = 16'h0101; bus_wstrb = 2'b11; bus_wen = 1'b1;
    hw_set[DW*3 + 0] = 1'b1; hw_clr[DW*3 + 0] = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; hw_set = '0; hw_clr = '0;
    keep = 16'h01FF;
    exp_q[3] = keep;
    check(field_q[DW*3 +: DW] === keep, "R8", field_q[DW*3 +: DW], keep);
    check_fields("R8");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule